// File: doc/BRIEF.md
# Seven-Channel DMA Request Arbiter

This block keeps the programming state of seven DMA channels and decides which one may move data next. Each channel owns three registers: a start address, a block geometry word and a control word. One shared register holds a priority field and an enable bit per channel. Peripherals drive one request line per channel. A CPU-side port writes and reads every register.

The arbiter runs a two-state machine. In **ARB_IDLE** it watches the per-channel eligibility vector. On the **issue** transition (any channel eligible) it moves to **ARB_ACTIVE**. There it latches the lowest-indexed eligible channel, together with a snapshot of that channel's word-aligned address, decoded geometry, direction and step sense. It also drops that channel's software trigger. The machine stays in ARB_ACTIVE (the **hold** self-loop) until the transfer engine returns a completion pulse. The **retire** transition back to ARB_IDLE clears the granted channel's busy bit. ARB_IDLE loops on itself (the **wait** self-loop) while nothing is eligible. The memory data path and list walking live in the transfer engine, outside this block.

Top module: `dma_chan_arbiter`

## Requirements
- R1: After reset the shared register reads 0x07654321, every channel register reads 0 and grant_valid is low.
- R2: The address register of each channel keeps bits 23:0 and reads bits 31:24 as zero. grant_addr equals the stored address ANDed with 0x001FFFFC.
- R3: A control write stores only the bits in mask 0x71770703, and all other bits read as zero. The control layout is: bit 0 direction (1 = memory to device), bit 1 reverse step, bits 10:9 mode (0 manual, 1 request, 2 list, 3 reserved), bit 24 busy, bit 28 trigger.
- R4: Channel n sits at byte offset 16·n, with the address at +0x0, geometry at +0x4 and control at +0x8. The shared register sits at 0x70 and all 32 of its bits are writable. Channel n's enable is bit 4n+3 of the shared register. Any other offset reads as 0, and writes to it change nothing.
- R5: A channel is eligible only when three conditions hold: its enable bit is set, its busy bit is set, and a start condition is present. In manual mode the start condition is the trigger bit. In the other modes it is the channel's request input. When the machine is idle, grant_valid rises at the first clock edge that sees a channel eligible.
- R6: When several channels are eligible at once, the lowest channel index is granted.
- R7: Only one grant exists at a time. grant_chan and its fields hold steady until completion, and a newly eligible channel does not pre-empt the current grant.
- R8: A completion pulse during a grant clears that channel's busy bit, and grant_valid falls at the same edge. A completion pulse while idle changes nothing.
- R9: Issuing a grant clears the channel's trigger bit. In manual mode grant_size is geometry bits 15:0, a value of 0 means 65536, and grant_count is 1.
- R10: In request mode grant_size is bits 15:0 and grant_count is bits 31:16, and a zero field means 65536. In list and reserved modes both are 0. grant_mode carries the mode field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data, combinational |
| dev_req | input | 7 | Per-channel peripheral request |
| xfer_done | input | 1 | Completion pulse from the transfer engine |
| grant_valid | output | 1 | A grant is active |
| grant_chan | output | 3 | Granted channel index |
| grant_addr | output | 24 | Word-aligned start address |
| grant_size | output | 17 | Words per block |
| grant_count | output | 17 | Number of blocks |
| grant_to_dev | output | 1 | 1 = memory to device |
| grant_step_back | output | 1 | Address decrements |
| grant_mode | output | 2 | Mode of the granted channel |

## Verification
The bench builds the block with its defaults: seven channels and an 8-bit offset. With these values the shared register falls on the slot just past channel 6. That layout brings several cases within reach: every enable nibble, a tie between channels 2 and 6, and a late manual trigger on channel 0 that must wait behind an active grant. One vector table covers all four modes, including both zero-means-65536 fields and the reserved mode. Directed cases cover masking, disabled and request-less channels, and a completion pulse that arrives while the machine is idle.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
    localparam int NUM_CH = 7;

    localparam logic [31:0] BASE_KEEP      = 32'h00FF_FFFF;
    localparam logic [31:0] XFER_ADDR_MASK = 32'h001F_FFFC;
    localparam logic [31:0] CTL_KEEP       = 32'h7177_0703;
    localparam logic [31:0] ARB_RESET      = 32'h0765_4321;

    localparam int CTL_DIR     = 0;
    localparam int CTL_STEP    = 1;
    localparam int CTL_MODE_LO = 9;
    localparam int CTL_MODE_HI = 10;
    localparam int CTL_BUSY    = 24;
    localparam int CTL_TRIG    = 28;

    typedef enum logic [1:0] {
        MODE_MANUAL  = 2'd0,
        MODE_REQUEST = 2'd1,
        MODE_LIST    = 2'd2,
        MODE_RSVD    = 2'd3
    } sync_mode_e;

    typedef enum logic {
        ARB_IDLE   = 1'b0,
        ARB_ACTIVE = 1'b1
    } arb_state_e;

    typedef struct packed {
        logic [23:0] addr;
        logic [16:0] size;
        logic [16:0] count;
        logic        to_dev;
        logic        step_back;
        sync_mode_e  mode;
    } grant_info_t;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_arb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_base,
    input  logic        wr_blk,
    input  logic        wr_ctl,
    input  logic [31:0] wdata,
    input  logic        hw_clr_busy,
    input  logic        hw_clr_trig,
    output logic [31:0] base_q,
    output logic [31:0] blk_q,
    output logic [31:0] ctl_q
);
    logic [31:0] ctl_next;

    // Hardware clears are applied after a software write in the same cycle.
    always_comb begin
        ctl_next = wr_ctl ? (wdata & CTL_KEEP) : ctl_q;
        if (hw_clr_busy) ctl_next[CTL_BUSY] = 1'b0;
        if (hw_clr_trig) ctl_next[CTL_TRIG] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            blk_q  <= '0;
            ctl_q  <= '0;
        end else begin
            if (wr_base) base_q <= wdata & BASE_KEEP;
            if (wr_blk)  blk_q  <= wdata;
            if (wr_ctl || hw_clr_busy || hw_clr_trig) ctl_q <= ctl_next;
        end
    end

    p_busy_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr_busy |=> !ctl_q[CTL_BUSY]);

    p_trig_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hw_clr_trig |=> !ctl_q[CTL_TRIG]);

    p_ctl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ctl && !hw_clr_busy && !hw_clr_trig) |=> $stable(ctl_q));

    p_base_top_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_base |=> (base_q[31:24] == 8'h00));
endmodule

// File: rtl/dma_low_pick.sv
module dma_low_pick #(
    parameter int N = 7,
    parameter int W = 3
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/dma_geom_decode.sv
module dma_geom_decode
    import dma_arb_pkg::*;
#(
    parameter  int FW = 16,
    localparam int XW = FW + 1
) (
    input  logic [2*FW-1:0] blk,
    input  sync_mode_e      mode,
    output logic [XW-1:0]   size,
    output logic [XW-1:0]   count
);
    function automatic logic [XW-1:0] widen(input logic [FW-1:0] f);
        return (f == '0) ? {1'b1, {FW{1'b0}}} : {1'b0, f};
    endfunction

    always_comb begin
        unique case (mode)
            MODE_MANUAL: begin
                size  = widen(blk[FW-1:0]);
                count = XW'(1);
            end
            MODE_REQUEST: begin
                size  = widen(blk[FW-1:0]);
                count = widen(blk[2*FW-1:FW]);
            end
            default: begin
                size  = '0;
                count = '0;
            end
        endcase
    end
endmodule

// File: rtl/dma_chan_arbiter.sv
module dma_chan_arbiter
    import dma_arb_pkg::*;
#(
    parameter  int NCH = NUM_CH,
    parameter  int AW  = 8,
    localparam int CW  = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [31:0]    wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [31:0]    rd_data,
    input  logic [NCH-1:0] dev_req,
    input  logic           xfer_done,
    output logic           grant_valid,
    output logic [CW-1:0]  grant_chan,
    output logic [23:0]    grant_addr,
    output logic [16:0]    grant_size,
    output logic [16:0]    grant_count,
    output logic           grant_to_dev,
    output logic           grant_step_back,
    output logic [1:0]     grant_mode
);
    localparam int SLOT_W = AW - 4;
    localparam logic [SLOT_W-1:0] SHARED_SLOT = SLOT_W'(NCH);

    logic [SLOT_W-1:0] wr_slot, rd_slot;
    logic [1:0]        wr_sel, rd_sel;
    logic              wr_ok;

    assign wr_slot = wr_addr[AW-1:4];
    assign wr_sel  = wr_addr[3:2];
    assign wr_ok   = wr_en && (wr_addr[1:0] == 2'b00);
    assign rd_slot = rd_addr[AW-1:4];
    assign rd_sel  = rd_addr[3:2];

    arb_state_e  state_q, state_d;
    logic        issue, retire;
    logic [CW-1:0] chan_q;
    grant_info_t info_q, pick_info;

    logic [31:0] arb_q;
    logic [31:0] base_r [NCH];
    logic [31:0] blk_r  [NCH];
    logic [31:0] ctl_r  [NCH];
    logic [NCH-1:0] elig;

    logic          pick_any;
    logic [CW-1:0] pick_idx;

    // Shared priority / enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arb_q <= ARB_RESET;
        else if (wr_ok && wr_slot == SHARED_SLOT && wr_sel == 2'd0) arb_q <= wr_data;
    end

    // Per-channel register banks and eligibility
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(c);
        localparam logic [CW-1:0]     MY_IDX  = CW'(c);
        logic hit;
        logic manual;
        assign hit    = wr_ok && (wr_slot == MY_SLOT);
        assign manual = (ctl_r[c][CTL_MODE_HI:CTL_MODE_LO] == MODE_MANUAL);

        dma_chan_regs u_regs (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_base     (hit && wr_sel == 2'd0),
            .wr_blk      (hit && wr_sel == 2'd1),
            .wr_ctl      (hit && wr_sel == 2'd2),
            .wdata       (wr_data),
            .hw_clr_busy (retire && chan_q == MY_IDX),
            .hw_clr_trig (issue && pick_idx == MY_IDX),
            .base_q      (base_r[c]),
            .blk_q       (blk_r[c]),
            .ctl_q       (ctl_r[c])
        );

        assign elig[c] = arb_q[4*c+3] && ctl_r[c][CTL_BUSY] &&
                         (manual ? ctl_r[c][CTL_TRIG] : dev_req[c]);
    end

    dma_low_pick #(.N(NCH), .W(CW)) u_pick (
        .req (elig),
        .any (pick_any),
        .idx (pick_idx)
    );

    logic [31:0] pick_base, pick_blk, pick_ctl;
    logic [16:0] pick_size, pick_count;
    sync_mode_e  pick_mode;

    assign pick_base = base_r[pick_idx];
    assign pick_blk  = blk_r[pick_idx];
    assign pick_ctl  = ctl_r[pick_idx];
    assign pick_mode = sync_mode_e'(pick_ctl[CTL_MODE_HI:CTL_MODE_LO]);

    dma_geom_decode #(.FW(16)) u_geom (
        .blk   (pick_blk),
        .mode  (pick_mode),
        .size  (pick_size),
        .count (pick_count)
    );

    always_comb begin
        pick_info.addr      = pick_base[23:0] & XFER_ADDR_MASK[23:0];
        pick_info.size      = pick_size;
        pick_info.count     = pick_count;
        pick_info.to_dev    = pick_ctl[CTL_DIR];
        pick_info.step_back = pick_ctl[CTL_STEP];
        pick_info.mode      = pick_mode;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // Next state: wait, issue, hold, retire
    always_comb begin
        state_d = state_q;
        issue   = 1'b0;
        retire  = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (pick_any) begin
                    state_d = ARB_ACTIVE;
                    issue   = 1'b1;
                end
            end
            ARB_ACTIVE: begin
                if (xfer_done) begin
                    state_d = ARB_IDLE;
                    retire  = 1'b1;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // Grant snapshot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
            info_q <= '0;
        end else if (issue) begin
            chan_q <= pick_idx;
            info_q <= pick_info;
        end
    end

    // Outputs
    always_comb begin
        grant_valid     = (state_q == ARB_ACTIVE);
        grant_chan      = chan_q;
        grant_addr      = info_q.addr;
        grant_size      = info_q.size;
        grant_count     = info_q.count;
        grant_to_dev    = info_q.to_dev;
        grant_step_back = info_q.step_back;
        grant_mode      = info_q.mode;
    end

    // Register readback
    always_comb begin
        rd_data = '0;
        if (rd_addr[1:0] == 2'b00) begin
            if (rd_slot == SHARED_SLOT) begin
                if (rd_sel == 2'd0) rd_data = arb_q;
            end else begin
                for (int c = 0; c < NCH; c++) begin
                    if (rd_slot == SLOT_W'(c)) begin
                        case (rd_sel)
                            2'd0:    rd_data = base_r[c];
                            2'd1:    rd_data = blk_r[c];
                            2'd2:    rd_data = ctl_r[c];
                            default: rd_data = '0;
                        endcase
                    end
                end
            end
        end
    end

    logic [NCH-1:0] low_mask;
    assign low_mask = (NCH'(1) << pick_idx) - NCH'(1);

    p_lowest_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (elig[pick_idx] && ((elig & low_mask) == '0)));

    p_grant_from_pick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_valid) |-> (grant_chan == $past(pick_idx)));

    p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && elig == '0) |=> !grant_valid);

    p_hold_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !xfer_done) |=> (grant_valid && $stable(grant_chan) && $stable(grant_addr)));

    p_retire_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && xfer_done) |=> !grant_valid);
endmodule

// File: tb/dma_chan_arbiter_test.sv
module dma_chan_arbiter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [6:0]  dev_req = '0;
    logic        xfer_done = 1'b0;
    logic        grant_valid;
    logic [2:0]  grant_chan;
    logic [23:0] grant_addr;
    logic [16:0] grant_size, grant_count;
    logic        grant_to_dev, grant_step_back;
    logic [1:0]  grant_mode;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dma_chan_arbiter uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .dev_req(dev_req), .xfer_done(xfer_done),
        .grant_valid(grant_valid), .grant_chan(grant_chan), .grant_addr(grant_addr),
        .grant_size(grant_size), .grant_count(grant_count), .grant_to_dev(grant_to_dev),
        .grant_step_back(grant_step_back), .grant_mode(grant_mode)
    );

    typedef struct packed {
        logic [2:0]  chan;
        logic        req;
        logic [31:0] ctl;
        logic [31:0] blk;
        logic [31:0] base;
        logic [16:0] size;
        logic [16:0] count;
        logic [23:0] addr;
        logic        to_dev;
        logic        step;
        logic [1:0]  mode;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b0, 32'h1100_0001, 32'h0000_0010, 32'h0012_3456, 17'd16,    17'd1,     24'h123454, 1'b1, 1'b0, 2'd0},
        '{3'd1, 1'b0, 32'h1100_0002, 32'hABCD_0000, 32'h00FF_FFFF, 17'h10000, 17'd1,     24'h1FFFFC, 1'b0, 1'b1, 2'd0},
        '{3'd3, 1'b1, 32'h0100_0200, 32'h0004_0010, 32'h0000_0100, 17'd16,    17'd4,     24'h000100, 1'b0, 1'b0, 2'd1},
        '{3'd4, 1'b1, 32'h0100_0201, 32'h0000_0000, 32'h0020_0008, 17'h10000, 17'h10000, 24'h000008, 1'b1, 1'b0, 2'd1},
        '{3'd5, 1'b1, 32'h0100_0400, 32'h0005_0005, 32'h0000_ABCF, 17'd0,     17'd0,     24'h00ABCC, 1'b0, 1'b0, 2'd2},
        '{3'd2, 1'b1, 32'h0100_0600, 32'h0002_0003, 32'h0000_0001, 17'd0,     17'd0,     24'h000000, 1'b0, 1'b0, 2'd3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_grant(output int cyc);
        cyc = 0;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (grant_valid) begin
                cyc = i;
                break;
            end
        end
    endtask

    task automatic pulse_done();
        @(negedge clk);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int cyc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 grant_valid", {31'd0, grant_valid}, 32'd0);
        rd(8'h70, d); chk("R1 shared reset", d, 32'h0765_4321);
        rd(8'h08, d); chk("R1 ch0 control", d, 32'd0);
        rd(8'h64, d); chk("R1 ch6 geometry", d, 32'd0);

        // R3 control mask; ch1 is disabled at reset so no grant (R5)
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, d); chk("R3 control mask", d, 32'h7177_0703);
        idle_cycles(3);
        chk("R5 disabled channel no grant", {31'd0, grant_valid}, 32'd0);
        wr(8'h18, 32'h0);

        // R2 address keep bits
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, d); chk("R2 address keep", d, 32'h00FF_FFFF);

        // R4 map: unmapped offsets, shared register
        wr(8'h74, 32'h1234_5678);
        rd(8'h74, d); chk("R4 unmapped 0x74", d, 32'd0);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, d); chk("R4 unmapped 0x0C", d, 32'd0);
        rd(8'h08, d); chk("R4 ch0 untouched", d, 32'd0);
        wr(8'h70, 32'h0FED_CBA9);
        rd(8'h70, d); chk("R4 shared write", d, 32'h0FED_CBA9);

        // Table-driven walk over modes (R2 R5 R8 R9 R10)
        for (int k = 0; k < NV; k++) begin
            vec_t v;
            logic [7:0] cb;
            v = VECS[k];
            cb = {1'b0, v.chan, 4'h0};
            wr(cb | 8'h0, v.base);
            wr(cb | 8'h4, v.blk);
            dev_req = v.req ? (7'd1 << v.chan) : 7'd0;
            wr(cb | 8'h8, v.ctl);
            wait_grant(cyc);
            chk("R5 grant one cycle after eligible", cyc, 1);
            chk("R5 grant channel", {29'd0, grant_chan}, {29'd0, v.chan});
            chk("R2 grant address", {8'd0, grant_addr}, {8'd0, v.addr});
            chk("R10 grant size", {15'd0, grant_size}, {15'd0, v.size});
            chk("R10 grant count", {15'd0, grant_count}, {15'd0, v.count});
            chk("R3 direction and step", {30'd0, grant_to_dev, grant_step_back}, {30'd0, v.to_dev, v.step});
            chk("R10 grant mode", {30'd0, grant_mode}, {30'd0, v.mode});
            rd(cb | 8'h8, d); chk("R9 trigger cleared at grant", d, v.ctl & 32'hEFFF_FFFF);
            pulse_done();
            chk("R8 grant drops on done", {31'd0, grant_valid}, 32'd0);
            rd(cb | 8'h8, d); chk("R8 busy cleared", d, v.ctl & 32'hEEFF_FFFF);
            dev_req = 7'd0;
            idle_cycles(1);
        end

        // R5 manual channel ignores request line without trigger
        dev_req = 7'b000_0001;
        wr(8'h08, 32'h0100_0000);
        idle_cycles(3);
        chk("R5 manual needs trigger", {31'd0, grant_valid}, 32'd0);
        wr(8'h08, 32'h0);
        dev_req = 7'd0;

        // R5 request mode without request, then without enable
        wr(8'h38, 32'h0100_0200);
        idle_cycles(3);
        chk("R5 request mode needs request", {31'd0, grant_valid}, 32'd0);
        wr(8'h70, 32'h0FED_4BA9);
        dev_req = 7'b000_1000;
        idle_cycles(3);
        chk("R5 enable bit gates channel", {31'd0, grant_valid}, 32'd0);
        wr(8'h70, 32'h0FED_CBA9);
        wait_grant(cyc);
        chk("R5 grant after enable", {31'd0, grant_valid}, 32'd1);
        chk("R5 granted ch3", {29'd0, grant_chan}, 32'd3);
        pulse_done();
        dev_req = 7'd0;

        // R6 tie between ch6 and ch2; R7 no pre-emption by ch0
        wr(8'h28, 32'h0100_0200);
        wr(8'h68, 32'h0100_0200);
        idle_cycles(2);
        chk("R5 no request yet", {31'd0, grant_valid}, 32'd0);
        @(negedge clk);
        dev_req = 7'b100_0100;
        wait_grant(cyc);
        chk("R6 lowest index wins", {29'd0, grant_chan}, 32'd2);
        wr(8'h08, 32'h1100_0000);
        idle_cycles(3);
        chk("R7 grant held", {29'd0, grant_chan}, 32'd2);
        chk("R7 still valid", {31'd0, grant_valid}, 32'd1);
        pulse_done();
        wait_grant(cyc);
        chk("R6 ch0 before ch6", {29'd0, grant_chan}, 32'd0);
        rd(8'h08, d); chk("R9 ch0 trigger cleared", d, 32'h0100_0000);
        pulse_done();
        wait_grant(cyc);
        chk("R6 ch6 last", {29'd0, grant_chan}, 32'd6);
        pulse_done();
        idle_cycles(2);
        chk("R8 idle after all retired", {31'd0, grant_valid}, 32'd0);
        dev_req = 7'd0;

        // R8 done while idle is ignored
        wr(8'h48, 32'h0100_0200);
        pulse_done();
        rd(8'h48, d); chk("R8 idle done keeps busy", d, 32'h0100_0200);
        chk("R8 idle done no grant", {31'd0, grant_valid}, 32'd0);
        dev_req = 7'b001_0000;
        wait_grant(cyc);
        chk("R8 busy still usable", {29'd0, grant_chan}, 32'd4);
        pulse_done();
        dev_req = 7'd0;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule